// File: doc/BRIEF.md
# System Coprocessor Status/Cause Controller

This block holds the privileged control word and the exception-reason word of a simple in-order processor's system coprocessor. Both sit in a small indexed register space next to general storage slots. The low bits of the control word form a stack of mode levels. Each level is two bits wide: a privilege bit and an interrupt-enable bit. Taking an exception pushes the stack. Returning from an exception pops it.

The pipeline reaches the block in four ways. It writes through an indexed write port. It reads back through a combinational read port. It pulses an entry strobe with a 5-bit reason code and a branch-delay flag when an exception is taken. It pulses a return strobe on return from exception. The block raises a software interrupt request whenever one of the two software-pending bits in the reason word is set, the matching mask bit in the control word is set, and the global enable is set. The request is recomputed from the stored words, so it follows every write to either of them. A system call enters with reason code 8, which puts 0x20 in the low byte of the reason word.

Top module: `cop_state_ctrl`

## Requirements
- R1: After asynchronous reset every register index reads 0 and `irq_o` is low.
- R2: Indices other than 12 and 13 are plain 32-bit storage. A write stores the full word. The read port returns the word at `rd_idx_i` combinationally, in the same cycle the index changes.
- R3: A write to index 12 (control word) stores all 32 bits as given.
- R4: A write to index 13 (reason word) stores the data with bits [15:10] forced to 0. All other bits are stored as given.
- R5: A return strobe replaces control bits [3:0] with the old bits [5:2]. Bits [31:4], including [5:4], keep their values. The reason word is not changed.
- R6: An entry strobe moves control bits [3:0] into bits [5:2] and clears bits [1:0]. Bits [31:6] are not changed.
- R7: An entry strobe writes the branch-delay flag into reason bit 31 and the code into reason bits [6:2]. All other reason bits are kept. Code 8 with the flag set turns a zero reason word into 0x80000020.
- R8: `irq_o` is high exactly when control bit 0 is 1 and (control & reason & 0x300) is nonzero. It reflects a write to either word from the cycle after that write.
- R9: A register write is dropped in any cycle in which the entry or return strobe is high. When both strobes are high, only the entry takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | 5 | Register write index |
| wr_data_i | input | 32 | Register write data |
| rd_idx_i | input | 5 | Register read index |
| rd_data_o | output | 32 | Combinational read data |
| ret_i | input | 1 | Return-from-exception strobe |
| exc_i | input | 1 | Exception-entry strobe |
| exc_code_i | input | 5 | Exception reason code |
| exc_bd_i | input | 1 | Exception taken in a branch-delay slot |
| irq_o | output | 1 | Software interrupt request |

## Verification
The bench builds the block with its defaults: 32 slots, control at 12, reason at 13, three stack levels, two software-pending bits at 8, and six protected bits at 10. With only three levels, a few pushes in a row show the oldest level falling off the top. Repeated pops show bits [5:4] being copied downward. The 32-slot space is small enough that random writes hit the control and reason words often. This brings simultaneous strobe-and-write cycles and interrupt mask toggling within reach of a short random run, which is checked every cycle against a behavioural model.

// File: rtl/cop_ctrl_pkg.sv
package cop_ctrl_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_WRITE = 2'd1,
    EV_POP   = 2'd2,
    EV_PUSH  = 2'd3
  } cop_ev_e;

  function automatic logic sw_irq(input word_t pend, input logic ie);
    return (|pend) && ie;
  endfunction
endpackage

// File: rtl/cop_ev_arb.sv
module cop_ev_arb
  import cop_ctrl_pkg::*;
#(
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned IDX_STATUS = 12,
  parameter int unsigned IDX_CAUSE  = 13
) (
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             ret_i,
  input  logic             exc_i,
  output cop_ev_e          ev_o,
  output logic             wr_stat_o,
  output logic             wr_cause_o,
  output logic             wr_gp_o
);
  // entry beats return beats write
  always_comb begin
    if (exc_i)        ev_o = EV_PUSH;
    else if (ret_i)   ev_o = EV_POP;
    else if (wr_en_i) ev_o = EV_WRITE;
    else              ev_o = EV_IDLE;
  end

  always_comb begin
    wr_stat_o  = 1'b0;
    wr_cause_o = 1'b0;
    wr_gp_o    = 1'b0;
    if (ev_o == EV_WRITE) begin
      if (wr_idx_i == IDX_W'(IDX_STATUS))     wr_stat_o  = 1'b1;
      else if (wr_idx_i == IDX_W'(IDX_CAUSE)) wr_cause_o = 1'b1;
      else                                    wr_gp_o    = 1'b1;
    end
  end
endmodule

// File: rtl/cop_stat_reg.sv
module cop_stat_reg
  import cop_ctrl_pkg::*;
#(
  parameter int unsigned STACK_LVLS = 3,
  parameter int unsigned LVL_W      = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  cop_ev_e ev_i,
  input  logic    wr_i,
  input  word_t   wr_data_i,
  output word_t   status_o
);
  localparam int unsigned STK_W = STACK_LVLS * LVL_W;

  word_t            status_q;
  logic [LVL_W-1:0] lvl_cur [STACK_LVLS];
  logic [LVL_W-1:0] lvl_psh [STACK_LVLS];
  logic [LVL_W-1:0] lvl_pop [STACK_LVLS];
  logic [STK_W-1:0] stk_psh, stk_pop;

  for (genvar l = 0; l < STACK_LVLS; l++) begin : g_lvl
    assign lvl_cur[l] = status_q[l*LVL_W +: LVL_W];
    if (l == 0) begin : g_bot
      assign lvl_psh[l] = '0;
    end else begin : g_mid
      assign lvl_psh[l] = lvl_cur[l-1];
    end
    if (l == STACK_LVLS - 1) begin : g_top
      assign lvl_pop[l] = lvl_cur[l];
    end else begin : g_low
      assign lvl_pop[l] = lvl_cur[l+1];
    end
  end

  always_comb begin
    for (int l = 0; l < STACK_LVLS; l++) begin
      stk_psh[l*LVL_W +: LVL_W] = lvl_psh[l];
      stk_pop[l*LVL_W +: LVL_W] = lvl_pop[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
    end else begin
      case (ev_i)
        EV_PUSH: status_q[STK_W-1:0] <= stk_psh;
        EV_POP:  status_q[STK_W-1:0] <= stk_pop;
        EV_WRITE: if (wr_i) status_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/cop_cause_reg.sv
module cop_cause_reg
  import cop_ctrl_pkg::*;
#(
  parameter int unsigned HW_LO   = 10,
  parameter int unsigned HW_N    = 6,
  parameter int unsigned CODE_LO = 2,
  parameter int unsigned CODE_W  = 5,
  parameter int unsigned BD_BIT  = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cop_ev_e           ev_i,
  input  logic              wr_i,
  input  word_t             wr_data_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              bd_i,
  output word_t             cause_o
);
  localparam word_t HW_MASK = word_t'(((64'd1 << HW_N) - 64'd1) << HW_LO);

  word_t cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
    end else begin
      case (ev_i)
        EV_PUSH: begin
          cause_q[BD_BIT]                <= bd_i;
          cause_q[CODE_LO +: CODE_W]     <= code_i;
        end
        EV_WRITE: if (wr_i) cause_q <= wr_data_i & ~HW_MASK;
        default: ;
      endcase
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/cop_gp_file.sv
module cop_gp_file
  import cop_ctrl_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 32,
  parameter int unsigned IDX_STATUS = 12,
  parameter int unsigned IDX_CAUSE  = 13,
  localparam int unsigned IDX_W     = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  word_t            wr_data_i,
  output word_t            slot_o [NUM_REGS]
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    if (i == IDX_STATUS || i == IDX_CAUSE) begin : g_hole
      assign slot_o[i] = '0;
    end else begin : g_store
      word_t q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               q <= '0;
        else if (wr_i && wr_idx_i == IDX_W'(i))    q <= wr_data_i;
      end
      assign slot_o[i] = q;
    end
  end
endmodule

// File: rtl/cop_state_ctrl.sv
module cop_state_ctrl
  import cop_ctrl_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 32,
  parameter int unsigned IDX_STATUS = 12,
  parameter int unsigned IDX_CAUSE  = 13,
  parameter int unsigned STACK_LVLS = 3,
  parameter int unsigned SWI_LO     = 8,
  parameter int unsigned SWI_N      = 2,
  parameter int unsigned HW_LO      = 10,
  parameter int unsigned HW_N       = 6,
  parameter int unsigned CODE_LO    = 2,
  parameter int unsigned CODE_W     = 5,
  parameter int unsigned BD_BIT     = 31,
  localparam int unsigned IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [31:0]       wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [31:0]       rd_data_o,
  input  logic              ret_i,
  input  logic              exc_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              exc_bd_i,
  output logic              irq_o
);
  localparam word_t SWI_MASK = word_t'(((64'd1 << SWI_N) - 64'd1) << SWI_LO);

  cop_ev_e ev;
  logic    wr_stat, wr_cause, wr_gp;
  word_t   status_w, cause_w;
  word_t   slots [NUM_REGS];

  cop_ev_arb #(
    .IDX_W(IDX_W), .IDX_STATUS(IDX_STATUS), .IDX_CAUSE(IDX_CAUSE)
  ) u_arb (
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .ret_i(ret_i), .exc_i(exc_i),
    .ev_o(ev), .wr_stat_o(wr_stat), .wr_cause_o(wr_cause), .wr_gp_o(wr_gp)
  );

  cop_stat_reg #(.STACK_LVLS(STACK_LVLS), .LVL_W(2)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(ev), .wr_i(wr_stat),
    .wr_data_i(wr_data_i), .status_o(status_w)
  );

  cop_cause_reg #(
    .HW_LO(HW_LO), .HW_N(HW_N), .CODE_LO(CODE_LO), .CODE_W(CODE_W), .BD_BIT(BD_BIT)
  ) u_cause (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(ev), .wr_i(wr_cause),
    .wr_data_i(wr_data_i), .code_i(exc_code_i), .bd_i(exc_bd_i), .cause_o(cause_w)
  );

  cop_gp_file #(
    .NUM_REGS(NUM_REGS), .IDX_STATUS(IDX_STATUS), .IDX_CAUSE(IDX_CAUSE)
  ) u_gp (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_gp), .wr_idx_i(wr_idx_i),
    .wr_data_i(wr_data_i), .slot_o(slots)
  );

  always_comb begin
    if (rd_idx_i == IDX_W'(IDX_STATUS))     rd_data_o = status_w;
    else if (rd_idx_i == IDX_W'(IDX_CAUSE)) rd_data_o = cause_w;
    else                                    rd_data_o = slots[rd_idx_i];
  end

  assign irq_o = sw_irq(status_w & cause_w & SWI_MASK, status_w[0]);
endmodule

// File: rtl/cop_ctrl_chk.sv
module cop_ctrl_chk #(
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned IDX_STATUS = 12,
  parameter int unsigned IDX_CAUSE  = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic [31:0]      wr_data_i,
  input logic             ret_i,
  input logic             exc_i,
  input logic [4:0]       exc_code_i,
  input logic             exc_bd_i,
  input logic [31:0]      status_w,
  input logic [31:0]      cause_w,
  input logic             irq_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  // R3
  stat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && wr_en_i && !exc_i && !ret_i && wr_idx_i == IDX_W'(IDX_STATUS))
    |=> status_w == $past(wr_data_i));

  // R4
  cause_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && wr_en_i && !exc_i && !ret_i && wr_idx_i == IDX_W'(IDX_CAUSE))
    |=> (cause_w[15:10] == 6'd0) && ({cause_w[31:16], cause_w[9:0]} ==
         {$past(wr_data_i[31:16]), $past(wr_data_i[9:0])}));

  // R5
  ret_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && ret_i && !exc_i)
    |=> (status_w[3:0] == $past(status_w[5:2])) && (status_w[31:4] == $past(status_w[31:4]))
        && $stable(cause_w));

  // R6
  entry_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && exc_i)
    |=> (status_w[5:0] == {$past(status_w[3:0]), 2'b00}) && (status_w[31:6] == $past(status_w[31:6])));

  // R7
  entry_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && exc_i)
    |=> (cause_w[31] == $past(exc_bd_i)) && (cause_w[6:2] == $past(exc_code_i))
        && (cause_w[30:7] == $past(cause_w[30:7])) && (cause_w[1:0] == $past(cause_w[1:0])));

  // R8
  irq_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_w[0]);

  // R8
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && wr_en_i && !exc_i && !ret_i && wr_idx_i == IDX_W'(IDX_CAUSE)
     && wr_data_i[8] && status_w[8] && status_w[0])
    |=> irq_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !exc_i && !ret_i && !wr_en_i) |=> $stable(status_w) && $stable(cause_w));
endmodule

bind cop_state_ctrl cop_ctrl_chk #(
  .IDX_W(IDX_W), .IDX_STATUS(IDX_STATUS), .IDX_CAUSE(IDX_CAUSE)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
  .wr_data_i(wr_data_i), .ret_i(ret_i), .exc_i(exc_i), .exc_code_i(exc_code_i),
  .exc_bd_i(exc_bd_i), .status_w(status_w), .cause_w(cause_w), .irq_o(irq_o)
);

// File: tb/cop_state_ctrl_tb_top.sv
module cop_state_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [4:0]  rd_idx_i = '0;
  logic [31:0] rd_data_o;
  logic        ret_i = 1'b0;
  logic        exc_i = 1'b0;
  logic [4:0]  exc_code_i = '0;
  logic        exc_bd_i = 1'b0;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_regs [32];

  always #4 clk_i = ~clk_i;

  cop_state_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_data_i(wr_data_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
    .ret_i(ret_i), .exc_i(exc_i), .exc_code_i(exc_code_i), .exc_bd_i(exc_bd_i),
    .irq_o(irq_o)
  );

  function automatic bit m_irq();
    return ((m_regs[12] & m_regs[13] & 32'h300) != 0) && m_regs[12][0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_rd(input int idx, input logic [31:0] exp, input string tag);
    rd_idx_i = 5'(idx);
    #1;
    chk(tag, rd_data_o, exp);
  endtask

  task automatic model_step();
    logic [31:0] s, c;
    s = m_regs[12];
    c = m_regs[13];
    if (exc_i) begin
      m_regs[12] = {s[31:6], s[3:0], 2'b00};
      m_regs[13] = {exc_bd_i, c[30:7], exc_code_i, c[1:0]};
    end else if (ret_i) begin
      m_regs[12] = {s[31:4], s[5:2]};
    end else if (wr_en_i) begin
      if (wr_idx_i == 5'd13) m_regs[13] = wr_data_i & 32'hFFFF_03FF;
      else                   m_regs[wr_idx_i] = wr_data_i;
    end
  endtask

  task automatic cyc(input bit we, input int idx, input logic [31:0] d,
                     input bit rt, input bit ex, input logic [4:0] cd,
                     input bit bd, input int ridx);
    string tag;
    wr_en_i = we; wr_idx_i = 5'(idx); wr_data_i = d;
    ret_i = rt; exc_i = ex; exc_code_i = cd; exc_bd_i = bd;
    rd_idx_i = 5'(ridx);
    @(posedge clk_i);
    model_step();
    #2;
    wr_en_i = 1'b0; ret_i = 1'b0; exc_i = 1'b0;
    tag = (ridx == 12) ? "R3" : (ridx == 13) ? "R4" : "R2";
    chk(tag, rd_data_o, m_regs[ridx]);
    chk("R8", {31'd0, irq_o}, {31'd0, m_irq()});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_regs[i] = '0;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(posedge clk_i); #2;

    // R1 reset state
    expect_rd(0, 32'h0, "R1");
    expect_rd(12, 32'h0, "R1");
    expect_rd(13, 32'h0, "R1");
    chk("R1", {31'd0, irq_o}, 32'd0);

    // R2 plain slot and combinational read
    cyc(1, 5, 32'hA5A5_5A5A, 0, 0, 0, 0, 5);
    expect_rd(5, 32'hA5A5_5A5A, "R2");
    expect_rd(12, 32'h0, "R2");

    // R3 full control write
    cyc(1, 12, 32'hFFFF_FFFF, 0, 0, 0, 0, 12);
    expect_rd(12, 32'hFFFF_FFFF, "R3");
    // R4 protected reason bits; R8 request
    cyc(1, 13, 32'hFFFF_FFFF, 0, 0, 0, 0, 13);
    expect_rd(13, 32'hFFFF_03FF, "R4");
    chk("R8", {31'd0, irq_o}, 32'd1);
    cyc(1, 13, 32'h0, 0, 0, 0, 0, 13);
    chk("R8", {31'd0, irq_o}, 32'd0);

    // R5 pop
    cyc(1, 12, 32'h0000_0A2C, 0, 0, 0, 0, 12);
    cyc(0, 0, 0, 1, 0, 0, 0, 12);
    expect_rd(12, 32'h0000_0A2B, "R5");
    expect_rd(13, 32'h0, "R5");

    // R6 R7 R9 push with competing write to control
    cyc(1, 12, 32'hDEAD_BEEF, 0, 1, 5'd8, 1, 12);
    expect_rd(12, 32'h0000_0A2C, "R6");
    expect_rd(13, 32'h8000_0020, "R7");
    chk("R9", rd_data_o, 32'h8000_0020);

    // R7 keeps other reason bits
    cyc(1, 13, 32'h0000_00FF, 0, 0, 0, 0, 13);
    cyc(0, 0, 0, 0, 1, 5'd3, 0, 13);
    expect_rd(13, 32'h0000_008F, "R7");
    expect_rd(12, 32'h0000_0A30, "R6");

    // R9 both strobes: entry wins
    cyc(0, 0, 0, 1, 1, 5'd1, 0, 12);
    expect_rd(12, 32'h0000_0A00, "R9");
    expect_rd(13, 32'h0000_0087, "R9");
    // R9 write dropped during return
    cyc(1, 7, 32'h1234_5678, 1, 0, 0, 0, 7);
    expect_rd(7, 32'h0, "R9");

    // R8 mask bit 9
    cyc(1, 12, 32'h0000_0201, 0, 0, 0, 0, 12);
    cyc(1, 13, 32'h0000_0200, 0, 0, 0, 0, 13);
    chk("R8", {31'd0, irq_o}, 32'd1);
    cyc(1, 12, 32'h0000_0200, 0, 0, 0, 0, 12);
    chk("R8", {31'd0, irq_o}, 32'd0);

    // random traffic against model
    for (int n = 0; n < 800; n++) begin
      int sel, idx, ridx;
      sel = int'($urandom % 4);
      idx = (sel == 0) ? 12 : (sel == 1) ? 13 : int'($urandom % 32);
      sel = int'($urandom % 3);
      ridx = (sel == 0) ? 12 : (sel == 1) ? 13 : int'($urandom % 32);
      cyc(bit'($urandom % 2), idx, $urandom, ($urandom % 8) == 0,
          ($urandom % 8) == 0, 5'($urandom), bit'($urandom % 2), ridx);
    end

    summary();
    $finish;
  end
endmodule